// File: doc/BRIEF.md
# Chain Node Relay with Sequential Addressing

This block is the digital behaviour of one node in a linear string of identical devices. The host talks only to the first node. Each node re-drives the forward lines (command serial data, active-low chain reset and busy) to the next node. Replies travel back toward the host on a separate reverse serial line. Every node merges its own reply frames into the traffic that arrives from the nodes further down the string.

Addresses are handed out by relay. After a reset, or after a chain-off command, a node holds no address and does not pass commands on. The first set-address command that reaches it gives it its address and opens its command relay, so the next set-address command reaches the next node. A read-identity command sent to the broadcast address or to the node's own address makes the node send a five-byte reply frame. The frame holds the reply preamble, the 16-bit device identifier given as a parameter, and the node's address.

Top module: `chain_node`

## Requirements
- R1: While `rst` is high, the outputs settle one clock later to `cmd_out`=1, `resp_out`=1, `rst_n_out`=0 and `busy_out`=0.
- R2: `rst_n_out` equals `rst_n_in` delayed by one clock, so it stays low while `rst_n_in` is low.
- R3: `busy_out` equals `busy_in` delayed by one clock.
- R4: A node without an address holds `cmd_out` at 1. A node with an address drives `cmd_out` with `cmd_in` delayed by one clock.
- R5: Serial lines use 8N1 framing: a low start bit, 8 data bits LSB first and a high stop bit, each lasting BIT_CYCLES clocks. A command is the four bytes 0x55, 0xAA, kind, target. The kinds are 0x01 set-address, 0x02 read-identity and 0x03 chain-off. A set-address command received with no address held stores the target byte as the node's address.
- R6: While an address is held, set-address commands are ignored and the stored address does not change.
- R7: A chain-off command whose target is 0x00 or the node's own address clears the address and closes the command relay. A later set-address command is accepted again.
- R8: A read-identity command whose target is 0x00 or the held address produces the reply bytes 0xAA, 0x55, ID[15:8], ID[7:0] and the address (0x00 when none is held) on `resp_out`. Any other target produces no reply.
- R9: Bytes received on `resp_in` are repeated on `resp_out` unchanged and in order.
- R10: Once a local reply has started, its five bytes go out back to back. Downstream bytes that arrive during the reply are buffered, up to FIFO_DEPTH of them, and sent after it with none lost.
- R11: Driving `rst_n_in` low clears the held address, so a later broadcast read-identity reply carries address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_in | input | 1 | Serial command line from the upstream node or the host |
| cmd_out | output | 1 | Serial command line to the downstream node |
| rst_n_in | input | 1 | Active-low chain reset from upstream |
| rst_n_out | output | 1 | Active-low chain reset to downstream |
| busy_in | input | 1 | Busy line from upstream |
| busy_out | output | 1 | Busy line to downstream |
| resp_in | input | 1 | Serial reply line from the downstream node |
| resp_out | output | 1 | Serial reply line toward upstream |

## Verification
A wrong address state shows up at the ports in two ways. The command relay is held shut, or opened, at the wrong time, and the mistake appears on `cmd_out` within one clock of the next `cmd_in` edge. The address byte of the next identity reply is also wrong, about one frame time after the command. A stuck parser or reply counter shows as a missing, short or extra reply frame. A fault in the buffer or the arbiter reorders or loses downstream bytes, and that appears only once the local reply has finished. The bench therefore overlaps downstream traffic with local replies and compares the complete byte sequence on `resp_out`.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;

    localparam logic [7:0] CMD_SYNC0  = 8'h55;
    localparam logic [7:0] CMD_SYNC1  = 8'hAA;
    localparam logic [7:0] RSP_SYNC0  = 8'hAA;
    localparam logic [7:0] RSP_SYNC1  = 8'h55;
    localparam logic [7:0] BCAST_ADDR = 8'h00;

    localparam logic [7:0] OP_SET_ADDR  = 8'h01;
    localparam logic [7:0] OP_READ_ID   = 8'h02;
    localparam logic [7:0] OP_CHAIN_OFF = 8'h03;

    localparam int REPLY_LEN   = 5;
    localparam int REPLY_IDX_W = 3;

    typedef enum logic [1:0] {P_SYNC0, P_SYNC1, P_KIND, P_TARGET} parse_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] value;
    } node_addr_t;

    function automatic logic [7:0] reply_byte(input logic [REPLY_IDX_W-1:0] idx,
                                              input logic [15:0] id,
                                              input logic [7:0] addr);
        case (idx)
            3'd0:    return RSP_SYNC0;
            3'd1:    return RSP_SYNC1;
            3'd2:    return id[15:8];
            3'd3:    return id[7:0];
            default: return addr;
        endcase
    endfunction

    function automatic logic target_hit(input node_addr_t a, input logic [7:0] tgt);
        return (tgt == BCAST_ADDR) || (a.valid && (a.value == tgt));
    endfunction

endpackage

// File: rtl/chain_node_rx.sv
module chain_node_rx #(
    parameter int BIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    localparam int CNT_W = $clog2(BIT_CYCLES);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BIT_CYCLES / 2 - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BIT_CYCLES - 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       idx;
    logic [7:0]       sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            sh         <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            case (st)
                RX_IDLE: if (!line) begin
                    st  <= RX_START;
                    cnt <= HALF;
                end
                RX_START: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!line) begin
                    st  <= RX_DATA;
                    cnt <= FULL;
                    idx <= '0;
                end else begin
                    st <= RX_IDLE;
                end
                RX_DATA: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    sh  <= {line, sh[7:1]};
                    cnt <= FULL;
                    if (idx == 3'd7) st <= RX_STOP;
                    else             idx <= idx + 1'b1;
                end
                default: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    byte_valid <= line;
                    st         <= RX_IDLE;
                end
            endcase
        end
    end

    assign byte_data = sh;
endmodule

// File: rtl/chain_node_tx.sv
module chain_node_tx #(
    parameter int BIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_valid,
    input  logic [7:0] load_data,
    output logic       ready,
    output logic       line
);
    localparam int CNT_W = $clog2(BIT_CYCLES);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BIT_CYCLES - 1);

    logic             busy;
    logic [9:0]       sh;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            cnt  <= '0;
            nbit <= '0;
        end else if (!busy) begin
            if (load_valid) begin
                busy <= 1'b1;
                sh   <= {1'b1, load_data, 1'b0};
                cnt  <= FULL;
                nbit <= '0;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            cnt <= FULL;
            sh  <= {1'b1, sh[9:1]};
            if (nbit == 4'd9) busy <= 1'b0;
            else              nbit <= nbit + 1'b1;
        end
    end

    assign ready = !busy;
    assign line  = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/chain_node_fifo.sv
module chain_node_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/chain_node.sv
module chain_node
    import chain_node_pkg::*;
#(
    parameter logic [15:0] CHIP_ID    = 16'h4D2B,
    parameter int          BIT_CYCLES = 8,
    parameter int          FIFO_DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_in,
    output logic cmd_out,
    input  logic rst_n_in,
    output logic rst_n_out,
    input  logic busy_in,
    output logic busy_out,
    input  logic resp_in,
    output logic resp_out
);
    logic node_clr;
    assign node_clr = rst || !rst_n_in;

    // forward path
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_out <= 1'b0;
            busy_out  <= 1'b0;
        end else begin
            rst_n_out <= rst_n_in;
            busy_out  <= busy_in;
        end
    end

    node_addr_t node_addr;
    logic       has_addr;
    assign has_addr = node_addr.valid;

    always_ff @(posedge clk) begin
        if (node_clr) cmd_out <= 1'b1;
        else          cmd_out <= has_addr ? cmd_in : 1'b1;
    end

    // command receive and parse
    logic       cmd_vld;
    logic [7:0] cmd_byte;

    chain_node_rx #(.BIT_CYCLES(BIT_CYCLES)) cmd_rx_i (
        .clk(clk), .rst(node_clr), .line(cmd_in),
        .byte_valid(cmd_vld), .byte_data(cmd_byte)
    );

    parse_e                 pst;
    logic [7:0]             kind;
    logic                   rep_active;
    logic [REPLY_IDX_W-1:0] rep_idx;
    logic                   tx_ready, tx_take;
    logic [7:0]             tx_data;
    logic                   fifo_empty, fifo_full, fifo_pop;
    logic [7:0]             fifo_head;

    always_ff @(posedge clk) begin
        if (node_clr) begin
            pst        <= P_SYNC0;
            kind       <= '0;
            node_addr  <= '0;
            rep_active <= 1'b0;
            rep_idx    <= '0;
        end else begin
            if (rep_active && tx_take) begin
                if (rep_idx == REPLY_IDX_W'(REPLY_LEN - 1)) rep_active <= 1'b0;
                else                                         rep_idx    <= rep_idx + 1'b1;
            end
            if (cmd_vld) begin
                case (pst)
                    P_SYNC0: if (cmd_byte == CMD_SYNC0) pst <= P_SYNC1;
                    P_SYNC1: begin
                        if (cmd_byte == CMD_SYNC1)      pst <= P_KIND;
                        else if (cmd_byte != CMD_SYNC0) pst <= P_SYNC0;
                    end
                    P_KIND: begin
                        kind <= cmd_byte;
                        pst  <= P_TARGET;
                    end
                    default: begin
                        pst <= P_SYNC0;
                        case (kind)
                            OP_SET_ADDR: if (!node_addr.valid)
                                node_addr <= '{valid: 1'b1, value: cmd_byte};
                            OP_CHAIN_OFF: if (target_hit(node_addr, cmd_byte))
                                node_addr <= '0;
                            OP_READ_ID: if (target_hit(node_addr, cmd_byte) && !rep_active) begin
                                rep_active <= 1'b1;
                                rep_idx    <= '0;
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    // reverse path: downstream bytes buffered, local reply wins at byte boundaries
    logic       rsp_vld;
    logic [7:0] rsp_byte;

    chain_node_rx #(.BIT_CYCLES(BIT_CYCLES)) rsp_rx_i (
        .clk(clk), .rst(node_clr), .line(resp_in),
        .byte_valid(rsp_vld), .byte_data(rsp_byte)
    );

    chain_node_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rsp_fifo_i (
        .clk(clk), .rst(node_clr),
        .push(rsp_vld && !fifo_full), .push_data(rsp_byte),
        .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full)
    );

    assign tx_take  = tx_ready && (rep_active || !fifo_empty);
    assign fifo_pop = tx_ready && !rep_active && !fifo_empty;
    assign tx_data  = rep_active ? reply_byte(rep_idx, CHIP_ID, node_addr.value) : fifo_head;

    chain_node_tx #(.BIT_CYCLES(BIT_CYCLES)) rsp_tx_i (
        .clk(clk), .rst(node_clr),
        .load_valid(tx_take), .load_data(tx_data),
        .ready(tx_ready), .line(resp_out)
    );
endmodule

// File: rtl/chain_node_chk.sv
module chain_node_chk (
    input logic clk,
    input logic rst,
    input logic rst_n_in,
    input logic rst_n_out,
    input logic busy_in,
    input logic busy_out,
    input logic cmd_out,
    input logic resp_out,
    input logic has_addr,
    input logic rep_active,
    input logic fifo_pop
);
    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        rst |=> (!rst_n_out && !busy_out && cmd_out && resp_out));

    // R2
    rst_chain_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_n_in |=> !rst_n_out);

    // R3
    busy_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (busy_out == $past(busy_in)));

    // R4
    relay_closed_chk: assert property (@(posedge clk) disable iff (rst)
        !has_addr |=> cmd_out);

    // R10
    local_first_chk: assert property (@(posedge clk) disable iff (rst)
        rep_active |-> !fifo_pop);

    // R11
    chain_rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_n_in |=> !has_addr);
endmodule

bind chain_node chain_node_chk chk_i (
    .clk(clk), .rst(rst), .rst_n_in(rst_n_in), .rst_n_out(rst_n_out),
    .busy_in(busy_in), .busy_out(busy_out), .cmd_out(cmd_out),
    .resp_out(resp_out), .has_addr(has_addr), .rep_active(rep_active),
    .fifo_pop(fifo_pop)
);

// File: tb/chain_node_tb_top.sv
module chain_node_tb_top;
    localparam int          BITC = 8;
    localparam logic [15:0] ID   = 16'h4D2B;
    localparam int          QUIET = BITC * 10 * 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_in = 1'b1, rst_n_in = 1'b0, busy_in = 1'b0, resp_in = 1'b1;
    logic cmd_out, rst_n_out, busy_out, resp_out;

    always #4 clk = ~clk;

    chain_node #(.CHIP_ID(ID), .BIT_CYCLES(BITC), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst(rst), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .rst_n_in(rst_n_in), .rst_n_out(rst_n_out),
        .busy_in(busy_in), .busy_out(busy_out),
        .resp_in(resp_in), .resp_out(resp_out)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // continuous models of the forward lines
    bit   fwd_m = 0, fwd_prev = 0, busy_chk = 0;
    logic cin_prev = 1'b1, busy_prev = 1'b0;
    int   fwd_err = 0, busy_err = 0, frame_err = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_out !== (fwd_prev ? cin_prev : 1'b1)) fwd_err++;
            if (busy_chk && busy_out !== busy_prev) busy_err++;
        end
        fwd_prev  = fwd_m;
        cin_prev  = cmd_in;
        busy_prev = busy_in;
    end

    // reply line decoder
    logic [7:0] rxq[$];
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && resp_out === 1'b0) begin
                logic [7:0] b;
                b = '0;
                repeat (BITC / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = resp_out;
                end
                repeat (BITC) @(negedge clk);
                if (resp_out !== 1'b1) frame_err++;
                rxq.push_back(b);
            end
        end
    end

    task automatic tx_byte(input bit to_resp, input logic [7:0] b);
        @(posedge clk); #1;
        for (int i = 0; i < 10; i++) begin
            logic v;
            v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
            if (to_resp) resp_in = v; else cmd_in = v;
            repeat (BITC) @(posedge clk);
            #1;
        end
    endtask

    task automatic send_cmd(input logic [7:0] kind, input logic [7:0] tgt);
        tx_byte(0, 8'h55); tx_byte(0, 8'hAA); tx_byte(0, kind); tx_byte(0, tgt);
    endtask

    function automatic logic [7:0] exp_reply(input int i, input logic [7:0] a);
        case (i)
            0: return 8'hAA;
            1: return 8'h55;
            2: return ID[15:8];
            3: return ID[7:0];
            default: return a;
        endcase
    endfunction

    task automatic quiet();
        repeat (QUIET) @(posedge clk);
    endtask

    task automatic expect_reply(input logic [7:0] a, input string req);
        quiet();
        check(rxq.size() == 5, req, "reply length", rxq.size(), 5);
        if (rxq.size() == 5)
            for (int i = 0; i < 5; i++)
                check(rxq[i] == exp_reply(i, a), req, $sformatf("reply byte %0d", i),
                      rxq[i], exp_reply(i, a));
        rxq.delete();
    endtask

    task automatic expect_none(input string req);
        quiet();
        check(rxq.size() == 0, req, "unexpected reply bytes", rxq.size(), 0);
        rxq.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] ds[$];
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (3) @(negedge clk);
        check(cmd_out === 1'b1 && resp_out === 1'b1 && rst_n_out === 1'b0 && busy_out === 1'b0,
              "R1", "reset outputs {cmd,resp,rstn,busy}",
              {cmd_out, resp_out, rst_n_out, busy_out}, 4'b1100);
        @(posedge clk); #1 rst = 1'b0;

        // R2 chain reset forwarding
        repeat (2) @(negedge clk);
        check(rst_n_out === 1'b0, "R2", "rst_n_out while input low", rst_n_out, 0);
        @(posedge clk); #1 rst_n_in = 1'b1;
        repeat (2) @(negedge clk);
        check(rst_n_out === 1'b1, "R2", "rst_n_out after release", rst_n_out, 1);

        // R3 busy forwarding under random pattern
        busy_chk = 1;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #1 busy_in = $urandom % 2;
        end
        @(posedge clk); #1 busy_in = 1'b0;
        repeat (2) @(negedge clk);
        check(busy_err == 0, "R3", "busy delay mismatches", busy_err, 0);

        // R8 broadcast read without address; R4 relay closed
        send_cmd(8'h02, 8'h00);
        expect_reply(8'h00, "R8");
        check(fwd_err == 0, "R4", "cmd_out while unaddressed", fwd_err, 0);

        // R5 address claim, relay opens
        send_cmd(8'h01, 8'h05);
        fwd_m = 1;
        expect_none("R5");
        send_cmd(8'h02, 8'h05);
        expect_reply(8'h05, "R5");
        check(fwd_err == 0, "R4", "cmd_out relay once addressed", fwd_err, 0);

        // R6 second set-address ignored
        send_cmd(8'h01, 8'h09);
        send_cmd(8'h02, 8'h09);
        expect_none("R6");
        send_cmd(8'h02, 8'h05);
        expect_reply(8'h05, "R6");

        // R9 downstream relay
        for (int i = 0; i < 6; i++) ds.push_back(8'($urandom));
        foreach (ds[i]) tx_byte(1, ds[i]);
        quiet();
        check(rxq.size() == 6, "R9", "relayed byte count", rxq.size(), 6);
        if (rxq.size() == 6)
            foreach (ds[i]) check(rxq[i] == ds[i], "R9", "relayed byte", rxq[i], ds[i]);
        rxq.delete();

        // R10 downstream bytes during local reply
        ds.delete();
        for (int i = 0; i < 4; i++) ds.push_back(8'($urandom));
        send_cmd(8'h02, 8'h00);
        foreach (ds[i]) tx_byte(1, ds[i]);
        quiet();
        check(rxq.size() == 9, "R10", "merged byte count", rxq.size(), 9);
        if (rxq.size() == 9) begin
            for (int i = 0; i < 5; i++)
                check(rxq[i] == exp_reply(i, 8'h05), "R10", "local byte", rxq[i], exp_reply(i, 8'h05));
            foreach (ds[i])
                check(rxq[5+i] == ds[i], "R10", "buffered byte", rxq[5+i], ds[i]);
        end
        rxq.delete();

        // R7 chain-off clears address and closes relay
        send_cmd(8'h03, 8'h00);
        fwd_m = 0;
        send_cmd(8'h02, 8'h05);
        expect_none("R7");
        check(fwd_err == 0, "R7", "cmd_out after chain-off", fwd_err, 0);
        send_cmd(8'h01, 8'h21);
        fwd_m = 1;
        send_cmd(8'h02, 8'h00);
        expect_reply(8'h21, "R7");

        // R8 random targets
        for (int i = 0; i < 6; i++) begin
            int unsigned r;
            logic [7:0] t;
            r = $urandom % 3;
            t = (r == 0) ? 8'h00 : (r == 1) ? 8'h21 : 8'h61;
            send_cmd(8'h02, t);
            if (r == 2) expect_none("R8");
            else        expect_reply(8'h21, "R8");
        end
        check(frame_err == 0, "R5", "stop bit errors on resp_out", frame_err, 0);

        // R11 chain reset clears address; R2 low propagation
        @(posedge clk); #1 rst_n_in = 1'b0;
        fwd_m = 0;
        repeat (2) @(negedge clk);
        check(rst_n_out === 1'b0, "R2", "rst_n_out follows low", rst_n_out, 0);
        repeat (4) @(posedge clk);
        #1 rst_n_in = 1'b1;
        send_cmd(8'h02, 8'h00);
        expect_reply(8'h00, "R11");
        check(fwd_err == 0, "R11", "relay closed after chain reset", fwd_err, 0);

        finish_run();
    end
endmodule